// File: doc/BRIEF.md
# Microoperation Datapath

This block holds three general-purpose registers and carries out one register-transfer microoperation on each clock edge. The operation is chosen by a 4-bit operation code. Operand A and operand B are picked by two source select fields, and a destination select field names the register that receives the result. The operation set is arithmetic (add or subtract through one shared adder, negate, one's complement, increment, decrement), bitwise logic (NOT, AND, OR, XOR), zero-fill shifts, shifts that take the fill bit from a link flip-flop, register moves, and a load of an external data word.

An enable input acts as the condition for the transfer. When the enable is low, nothing in the block changes. Every write also records three status flags alongside the result: zero, adder carry-out and signed overflow. A sequencer outside the block reads these flags to choose the next operation. Any register can act as source A, source B or destination, and in every field the select code 3 stands for "no register".

Top module: `rtm_unit`

## Requirements
- R1: While rst_ni is low, registers r0..r2, the link bit and all three flags are cleared to zero, whatever the clock is doing.
- R2: When en_i is 0 at a rising clock edge, no register, link bit or flag changes value.
- R3: With en_i=1 and a writing opcode (0..13), only the register selected by dst_i (0=r0, 1=r1, 2=r2) takes the result at the rising edge. dst_i=3 writes no register but still updates the flags. A source select of 3 reads as all zeros.
- R4: Opcode 13 (load) writes data_i and opcode 0 (move) writes operand A. Both leave carry and overflow at 0.
- R5: Opcode 1 with mode_i=0 writes A+B, and with mode_i=1 writes A+~B+1. carry_o takes the adder carry-out, which is 1 for "no borrow" in a subtract. ovf_o is set on two's-complement overflow.
- R6: Opcodes 2 (~A), 3 (~A+1), 4 (A+1) and 5 (A+all-ones) use the shared adder for 3, 4 and 5, and carry_o takes its carry-out. Opcode 2 gives carry 0. ovf_o is 0 for all four.
- R7: Opcodes 6, 7 and 8 write A AND B, A OR B and A XOR B. With A=AA and B=F0 (hex) the results are A0, FA and 5A, and NOT AA gives 55.
- R8: Opcodes 9 (left) and 10 (right) shift A by one place and fill the vacated bit with 0. The bit shifted out goes to link_o. C9 gives 92 to the left and 64 to the right.
- R9: Opcodes 11 (left) and 12 (right) shift A by one place and fill the vacated bit with the old link bit. The bit shifted out goes to link_o.
- R10: zero_o is 1 exactly when the written result is all zeros. carry_o and ovf_o are 0 after move, load, logic and shift operations. The flags keep their values between writes.
- R11: Opcodes 14 and 15 are reserved and change nothing, even when en_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Condition for the transfer; 0 blocks the operation |
| op_i | input | 4 | Operation code |
| mode_i | input | 1 | Selects add (0) or subtract (1) for opcode 1 |
| src_a_i | input | 2 | Operand A register select (3 = zero) |
| src_b_i | input | 2 | Operand B register select (3 = zero) |
| dst_i | input | 2 | Destination register select (3 = none) |
| data_i | input | WIDTH | External word for the load opcode |
| r0_o | output | WIDTH | Register r0 |
| r1_o | output | WIDTH | Register r1 |
| r2_o | output | WIDTH | Register r2 |
| link_o | output | 1 | Link bit |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Adder carry-out flag |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The bench builds the block with WIDTH=8. At that width the 8-bit example operands (AA, F0, C9) go straight through the logic and shift operations, and the carry and overflow edges sit at small values such as 7F, 80 and FF. Those points can be hit with single loads and compared against hand-worked results. The default 16-bit width is elaborated only, through the bound checker.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  typedef enum logic [3:0] {
    OP_MOVE    = 4'd0,
    OP_ADDSUB  = 4'd1,
    OP_NOT     = 4'd2,
    OP_NEG     = 4'd3,
    OP_INC     = 4'd4,
    OP_DEC     = 4'd5,
    OP_AND     = 4'd6,
    OP_OR      = 4'd7,
    OP_XOR     = 4'd8,
    OP_SHL     = 4'd9,
    OP_SHR     = 4'd10,
    OP_SHL_LNK = 4'd11,
    OP_SHR_LNK = 4'd12,
    OP_LOAD    = 4'd13,
    OP_RSV_E   = 4'd14,
    OP_RSV_F   = 4'd15
  } rtm_op_e;

  typedef struct packed {
    logic zero;
    logic carry;
    logic ovf;
  } rtm_flags_t;

  function automatic logic op_writes(rtm_op_e op);
    return op <= OP_LOAD;
  endfunction

  function automatic logic op_shifts(rtm_op_e op);
    return (op >= OP_SHL) && (op <= OP_SHR_LNK);
  endfunction
endpackage

// File: rtl/rtm_operand_sel.sv
module rtm_operand_sel #(
  parameter int WIDTH = 16,
  parameter int NREGS = 3,
  localparam int IDX_W = $clog2(NREGS + 1)
) (
  input  logic [NREGS-1:0][WIDTH-1:0] regs_i,
  input  logic [IDX_W-1:0]            sel_i,
  output logic [WIDTH-1:0]            data_o
);
  // codes at or above NREGS read as zero
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (sel_i == IDX_W'(i)) data_o = regs_i[i];
    end
  end
endmodule

// File: rtl/rtm_alu.sv
module rtm_alu
  import rtm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  rtm_op_e          op_i,
  input  logic             mode_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             link_i,
  output logic [WIDTH-1:0] res_o,
  output logic             link_o,
  output rtm_flags_t       flags_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] add_x, add_y;
  logic             cin;
  logic [WIDTH:0]   sum;
  logic             use_adder;

  // one adder shared by every arithmetic opcode
  always_comb begin
    add_x     = a_i;
    add_y     = b_i;
    cin       = 1'b0;
    use_adder = 1'b1;
    unique case (op_i)
      OP_ADDSUB: begin
        add_y = mode_i ? ~b_i : b_i;
        cin   = mode_i;
      end
      OP_NEG: begin
        add_x = '0;
        add_y = ~a_i;
        cin   = 1'b1;
      end
      OP_INC: begin
        add_y = '0;
        cin   = 1'b1;
      end
      OP_DEC: add_y = '1;
      default: use_adder = 1'b0;
    endcase
  end

  assign sum = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    res_o  = '0;
    link_o = link_i;
    unique case (op_i)
      OP_MOVE:    res_o = a_i;
      OP_LOAD:    res_o = data_i;
      OP_NOT:     res_o = ~a_i;
      OP_AND:     res_o = a_i & b_i;
      OP_OR:      res_o = a_i | b_i;
      OP_XOR:     res_o = a_i ^ b_i;
      OP_SHL: begin
        res_o  = {a_i[MSB-1:0], 1'b0};
        link_o = a_i[MSB];
      end
      OP_SHR: begin
        res_o  = {1'b0, a_i[MSB:1]};
        link_o = a_i[0];
      end
      OP_SHL_LNK: begin
        res_o  = {a_i[MSB-1:0], link_i};
        link_o = a_i[MSB];
      end
      OP_SHR_LNK: begin
        res_o  = {link_i, a_i[MSB:1]};
        link_o = a_i[0];
      end
      OP_ADDSUB, OP_NEG, OP_INC, OP_DEC: res_o = sum[MSB:0];
      default:    res_o = '0;
    endcase
  end

  always_comb begin
    flags_o.zero  = (res_o == '0);
    flags_o.carry = use_adder & sum[WIDTH];
    flags_o.ovf   = (op_i == OP_ADDSUB) && (add_x[MSB] == add_y[MSB])
                    && (sum[MSB] != add_x[MSB]);
  end
endmodule

// File: rtl/rtm_regfile.sv
module rtm_regfile #(
  parameter int WIDTH = 16,
  parameter int NREGS = 3,
  localparam int IDX_W = $clog2(NREGS + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            waddr_i,
  input  logic [WIDTH-1:0]            wdata_i,
  output logic [NREGS-1:0][WIDTH-1:0] regs_o
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (we_i && (waddr_i == IDX_W'(g)))    q <= wdata_i;
    end
    assign regs_o[g] = q;
  end
endmodule

// File: rtl/rtm_unit.sv
module rtm_unit
  import rtm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [3:0]       op_i,
  input  logic             mode_i,
  input  logic [1:0]       src_a_i,
  input  logic [1:0]       src_b_i,
  input  logic [1:0]       dst_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] r0_o,
  output logic [WIDTH-1:0] r1_o,
  output logic [WIDTH-1:0] r2_o,
  output logic             link_o,
  output logic             zero_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int NREGS = 3;

  rtm_op_e                    op;
  logic [NREGS-1:0][WIDTH-1:0] regs;
  logic [WIDTH-1:0]           opa, opb, res;
  logic                       link_q, link_nxt;
  rtm_flags_t                 flags_q, flags_nxt;
  logic                       wr_en;

  assign op    = rtm_op_e'(op_i);
  assign wr_en = en_i && op_writes(op);

  rtm_operand_sel #(.WIDTH(WIDTH), .NREGS(NREGS)) u_sel_a (
    .regs_i(regs), .sel_i(src_a_i), .data_o(opa)
  );

  rtm_operand_sel #(.WIDTH(WIDTH), .NREGS(NREGS)) u_sel_b (
    .regs_i(regs), .sel_i(src_b_i), .data_o(opb)
  );

  rtm_alu #(.WIDTH(WIDTH)) u_alu (
    .op_i   (op),
    .mode_i (mode_i),
    .a_i    (opa),
    .b_i    (opb),
    .data_i (data_i),
    .link_i (link_q),
    .res_o  (res),
    .link_o (link_nxt),
    .flags_o(flags_nxt)
  );

  rtm_regfile #(.WIDTH(WIDTH), .NREGS(NREGS)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en),
    .waddr_i(dst_i),
    .wdata_i(res),
    .regs_o (regs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q  <= 1'b0;
      flags_q <= '0;
    end else if (wr_en) begin
      flags_q <= flags_nxt;
      if (op_shifts(op)) link_q <= link_nxt;
    end
  end

  assign r0_o    = regs[0];
  assign r1_o    = regs[1];
  assign r2_o    = regs[2];
  assign link_o  = link_q;
  assign zero_o  = flags_q.zero;
  assign carry_o = flags_q.carry;
  assign ovf_o   = flags_q.ovf;
endmodule

// File: rtl/rtm_unit_chk.sv
module rtm_unit_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [3:0]       op_i,
  input logic             mode_i,
  input logic [1:0]       src_a_i,
  input logic [1:0]       src_b_i,
  input logic [1:0]       dst_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] r0_o,
  input logic [WIDTH-1:0] r1_o,
  input logic [WIDTH-1:0] r2_o,
  input logic             link_o,
  input logic             zero_o,
  input logic             carry_o,
  input logic             ovf_o
);
  logic             wr_q, ld_q;
  logic [1:0]       dst_q;
  logic [WIDTH-1:0] data_q, dst_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      ld_q   <= 1'b0;
      dst_q  <= 2'd3;
      data_q <= '0;
    end else begin
      wr_q   <= en_i && (op_i <= 4'd13);
      ld_q   <= op_i == 4'd13;
      dst_q  <= dst_i;
      data_q <= data_i;
    end
  end

  always_comb begin
    unique case (dst_q)
      2'd0:    dst_val = r0_o;
      2'd1:    dst_val = r1_o;
      2'd2:    dst_val = r2_o;
      default: dst_val = '0;
    endcase
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (r0_o == '0 && r1_o == '0 && r2_o == '0 &&
                               !link_o && !zero_o && !carry_o && !ovf_o);
    end
  end

  // R2
  inhibit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(r0_o) && $stable(r1_o) && $stable(r2_o) && $stable(link_o)
              && $stable(zero_o) && $stable(carry_o) && $stable(ovf_o));

  // R11
  reserved_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i >= 4'd14) |=> $stable(r0_o) && $stable(r1_o) && $stable(r2_o)
              && $stable(link_o) && $stable(zero_o) && $stable(carry_o) && $stable(ovf_o));

  // R3
  r0_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && op_i <= 4'd13 && dst_i == 2'd0) |=> $stable(r0_o));

  // R3
  r1_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && op_i <= 4'd13 && dst_i == 2'd1) |=> $stable(r1_o));

  // R3
  r2_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && op_i <= 4'd13 && dst_i == 2'd2) |=> $stable(r2_o));

  // R4
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q && ld_q && dst_q != 2'd3) |-> dst_val == data_q);

  // R10
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q && dst_q != 2'd3) |-> zero_o == (dst_val == '0));

  // R10
  no_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (op_i == 4'd0 || op_i == 4'd2 || (op_i >= 4'd6 && op_i <= 4'd13)))
      |=> !carry_o && !ovf_o);

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i >= 4'd2 && op_i <= 4'd5) |=> !ovf_o);
endmodule

bind rtm_unit rtm_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/rtm_unit_test.sv
module rtm_unit_test;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         en_i = 1'b0;
  logic [3:0]   op_i = '0;
  logic         mode_i = 1'b0;
  logic [1:0]   src_a_i = '0, src_b_i = '0, dst_i = 2'd3;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] r0_o, r1_o, r2_o;
  logic         link_o, zero_o, carry_o, ovf_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  rtm_unit #(.WIDTH(W)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // flags packed as {zero, carry, ovf}
  function automatic logic [2:0] flg();
    return {zero_o, carry_o, ovf_o};
  endfunction

  task automatic do_op(input logic [3:0] op, input logic [1:0] a, input logic [1:0] b,
                       input logic [1:0] d, input logic m = 1'b0,
                       input logic [W-1:0] dat = '0, input logic en = 1'b1);
    @(negedge clk_i);
    en_i = en; op_i = op; src_a_i = a; src_b_i = b; dst_i = d; mode_i = m; data_i = dat;
    @(negedge clk_i);
    en_i = 1'b0; op_i = '0; dst_i = 2'd3;
  endtask

  task automatic load(input logic [1:0] d, input logic [W-1:0] v);
    do_op(4'd13, 2'd0, 2'd0, d, 1'b0, v);
  endtask

  task automatic t_reset();
    chk("R1 r0", r0_o, 0); chk("R1 r1", r1_o, 0); chk("R1 r2", r2_o, 0);
    chk("R1 link", link_o, 0); chk("R1 flags", flg(), 0);
  endtask

  task automatic t_logic();
    load(2'd1, 8'hAA); load(2'd2, 8'hF0);
    chk("R4 load r1", r1_o, 8'hAA); chk("R4 load r2", r2_o, 8'hF0);
    chk("R3 r0 untouched", r0_o, 0);
    do_op(4'd6, 2'd1, 2'd2, 2'd0); chk("R7 and", r0_o, 8'hA0); chk("R10 and flags", flg(), 3'b000);
    do_op(4'd7, 2'd1, 2'd2, 2'd0); chk("R7 or", r0_o, 8'hFA);
    do_op(4'd8, 2'd1, 2'd2, 2'd0); chk("R7 xor", r0_o, 8'h5A);
    do_op(4'd2, 2'd1, 2'd0, 2'd0); chk("R7 not", r0_o, 8'h55); chk("R6 not flags", flg(), 3'b000);
  endtask

  task automatic t_move();
    do_op(4'd0, 2'd2, 2'd0, 2'd0); chk("R4 move", r0_o, 8'hF0);
    do_op(4'd0, 2'd3, 2'd0, 2'd0); chk("R3 src3 zero", r0_o, 0); chk("R10 zero flag", flg(), 3'b100);
  endtask

  task automatic t_addsub();
    do_op(4'd1, 2'd1, 2'd2, 2'd0, 1'b0); chk("R5 add carry", r0_o, 8'h9A); chk("R5 add flags", flg(), 3'b010);
    load(2'd1, 8'h70); load(2'd2, 8'h30);
    do_op(4'd1, 2'd1, 2'd2, 2'd0, 1'b0); chk("R5 add ovf", r0_o, 8'hA0); chk("R5 ovf flags", flg(), 3'b001);
    do_op(4'd1, 2'd1, 2'd2, 2'd0, 1'b1); chk("R5 sub", r0_o, 8'h40); chk("R5 sub flags", flg(), 3'b010);
    do_op(4'd1, 2'd2, 2'd1, 2'd0, 1'b1); chk("R5 rev sub", r0_o, 8'hC0); chk("R5 borrow flags", flg(), 3'b000);
    do_op(4'd1, 2'd1, 2'd1, 2'd0, 1'b1); chk("R5 self sub", r0_o, 0); chk("R5 self flags", flg(), 3'b110);
    load(2'd1, 8'h80);
    do_op(4'd1, 2'd1, 2'd2, 2'd0, 1'b1); chk("R5 sub ovf", r0_o, 8'h50); chk("R5 sub ovf flags", flg(), 3'b011);
  endtask

  task automatic t_unary();
    do_op(4'd3, 2'd2, 2'd0, 2'd0); chk("R6 neg", r0_o, 8'hD0); chk("R6 neg flags", flg(), 3'b000);
    do_op(4'd3, 2'd3, 2'd0, 2'd0); chk("R6 neg zero", r0_o, 0); chk("R6 neg0 flags", flg(), 3'b110);
    do_op(4'd4, 2'd2, 2'd0, 2'd2); chk("R6 inc", r2_o, 8'h31);
    load(2'd0, 8'hFF);
    do_op(4'd4, 2'd0, 2'd0, 2'd0); chk("R6 inc wrap", r0_o, 0); chk("R6 inc wrap flags", flg(), 3'b110);
    do_op(4'd5, 2'd0, 2'd0, 2'd0); chk("R6 dec wrap", r0_o, 8'hFF); chk("R6 dec flags", flg(), 3'b000);
    load(2'd0, 8'h01);
    do_op(4'd5, 2'd0, 2'd0, 2'd0); chk("R6 dec to zero", r0_o, 0); chk("R6 dec0 flags", flg(), 3'b110);
    load(2'd0, 8'h7F);
    do_op(4'd4, 2'd0, 2'd0, 2'd0); chk("R6 inc 7f", r0_o, 8'h80); chk("R6 inc no ovf", flg(), 3'b000);
  endtask

  task automatic t_shift();
    load(2'd2, 8'hC9);
    do_op(4'd9, 2'd2, 2'd0, 2'd1); chk("R8 shl", r1_o, 8'h92); chk("R8 shl link", link_o, 1);
    do_op(4'd10, 2'd2, 2'd0, 2'd1); chk("R8 shr zero fill", r1_o, 8'h64); chk("R8 shr link", link_o, 1);
    load(2'd0, 8'h80);
    do_op(4'd9, 2'd0, 2'd0, 2'd0); chk("R8 shl out", r0_o, 0); chk("R10 shift flags", flg(), 3'b100);
    chk("R8 shl out link", link_o, 1);
  endtask

  task automatic t_link();
    load(2'd0, 8'h02); chk("R9 load keeps link", link_o, 1);
    do_op(4'd12, 2'd0, 2'd0, 2'd0); chk("R9 shr link fill", r0_o, 8'h81); chk("R9 shr link out", link_o, 0);
    do_op(4'd11, 2'd0, 2'd0, 2'd0); chk("R9 shl link fill", r0_o, 8'h02); chk("R9 shl link out", link_o, 1);
    do_op(4'd11, 2'd0, 2'd0, 2'd0); chk("R9 shl fill one", r0_o, 8'h05); chk("R9 link clear", link_o, 0);
  endtask

  task automatic t_inhibit();
    do_op(4'd1, 2'd1, 2'd1, 2'd1, 1'b1);
    chk("R5 prep", r1_o, 0);
    do_op(4'd13, 2'd0, 2'd0, 2'd1, 1'b0, 8'h77, 1'b0);
    chk("R2 r1 held", r1_o, 0); chk("R2 flags held", flg(), 3'b110);
    do_op(4'd10, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00, 1'b0);
    chk("R2 r0 held", r0_o, 8'h05); chk("R2 link held", link_o, 0);
  endtask

  task automatic t_reserved();
    do_op(4'd14, 2'd0, 2'd0, 2'd1, 1'b0, 8'h33);
    chk("R11 op14 r1", r1_o, 0); chk("R11 op14 flags", flg(), 3'b110);
    do_op(4'd15, 2'd0, 2'd0, 2'd0, 1'b0, 8'h33);
    chk("R11 op15 r0", r0_o, 8'h05); chk("R11 op15 link", link_o, 0);
  endtask

  task automatic t_dst_none();
    load(2'd1, 8'h01); load(2'd2, 8'hFF);
    do_op(4'd1, 2'd1, 2'd2, 2'd3);
    chk("R3 dst3 r0", r0_o, 8'h05); chk("R3 dst3 r1", r1_o, 8'h01); chk("R3 dst3 r2", r2_o, 8'hFF);
    chk("R3 dst3 flags", flg(), 3'b110);
  endtask

  task automatic t_reset_mid();
    @(negedge clk_i); rst_ni = 1'b0;
    #3;
    chk("R1 async r1", r1_o, 0); chk("R1 async r2", r2_o, 0); chk("R1 async flags", flg(), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    chk("R1 after reset r0", r0_o, 0);
  endtask

  initial begin
    #5 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_logic();
    t_move();
    t_addsub();
    t_unary();
    t_shift();
    t_link();
    t_inhibit();
    t_reserved();
    t_dst_none();
    t_reset_mid();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule